// File: doc/BRIEF.md
# Bus-Matching Read Unpacker

This block sits between a queue that stores 36-bit long-words and a read port whose width is set to 36, 18 or 9 bits. In 36-bit mode every accepted read pops one long-word and puts the whole of it in the output register. In the two narrow modes one popped long-word is kept in a holding register. It is then delivered piece by piece over successive reads: two 18-bit halves, or four 9-bit bytes. The queue is popped again only after the last piece of the held long-word has been read.

The bus width and the piece order are captured once, on the first clock edge after reset is released. In big-endian order the most significant piece comes first, and in little-endian order the least significant piece comes first. The captured settings do not change until the next reset. In 36-bit mode the order input has no effect. A ready output tells the reader whether a read would be accepted. It stays high while held pieces remain, even when the queue is empty.

Top module: `bus_unpacker`

## Requirements
- R1: While reset is low, `dout_o` is zero and `rdy_o` and `q_pop_o` are low. The configuration is captured on the first rising clock edge after reset is released, and `rdy_o` stays low until that edge.
- R2: `size_i` and `big_end_i` are sampled only at that first edge. Later changes to either input have no effect on output order or width until the next reset.
- R3: With `size_i` = 2'b00 (36-bit mode), each accepted read pops the queue once and loads the full popped long-word into `dout_o` on the same clock edge. The code 2'b11 behaves as 2'b00.
- R4: With `size_i` = 2'b01 (18-bit mode), each long-word takes two accepted reads. Each read presents one 18-bit half on `dout_o[17:0]`; the half in lanes [17:0] is half 0 and the half in lanes [35:18] is half 1.
- R5: With `size_i` = 2'b10 (9-bit mode), each long-word takes four accepted reads. Each read presents one 9-bit byte on `dout_o[8:0]`; byte j occupies lanes [9j+8:9j].
- R6: In the narrow modes, `big_end_i` = 1 delivers the highest-numbered piece first and then descends. `big_end_i` = 0 delivers piece 0 first and then ascends.
- R7: In 36-bit mode the value of `big_end_i` has no effect on `dout_o`.
- R8: `rdy_o` is high after configuration when held pieces remain or `q_valid_i` is high. A read with `rdy_o` low is ignored: it causes no pop and leaves `dout_o` unchanged.
- R9: `dout_o` holds its value in every cycle without an accepted read.
- R10: `q_pop_o` is high only in a cycle with an accepted read that fetches a new long-word. That is the first piece of each long-word, and `q_valid_i` must be high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| size_i | input | 2 | Bus width select: 00 = 36, 01 = 18, 10 = 9, 11 = 36 |
| big_end_i | input | 1 | Piece order: 1 = most significant first |
| q_valid_i | input | 1 | Queue holds at least one long-word |
| q_data_i | input | 36 | Long-word at the head of the queue |
| q_pop_o | output | 1 | Remove the head long-word at this clock edge |
| rd_i | input | 1 | Read strobe |
| rdy_o | output | 1 | A read would be accepted this cycle |
| dout_o | output | 36 | Output register; lanes above the selected width are unspecified |

## Verification
The bench builds the block with its default parameters: four 9-bit lanes, so a 36-bit long-word. That keeps the whole configuration space small, four width codes and two orders, so the bench covers all eight combinations after separate resets. In each combination it streams several long-words with distinct lane values and computes every expected piece arithmetically from the width, the order and the piece index. The bench also reaches the cases around the ends of a long-word: held pieces while the queue is empty, a read refused once everything is drained, idle cycles in the middle of a long-word, and configuration inputs that change after the capture edge.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // lanes carried by one piece
  function automatic int unsigned lanes_per_piece(size_e s, int unsigned lanes);
    case (s)
      SZ_WORD: return lanes / 2;
      SZ_BYTE: return 1;
      default: return lanes;
    endcase
  endfunction

  // pieces per long-word
  function automatic int unsigned pieces(size_e s, int unsigned lanes);
    case (s)
      SZ_WORD: return 2;
      SZ_BYTE: return lanes;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
  import bm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] size_i,
  input  logic       big_end_i,
  output logic       done_o,
  output size_e      size_o,
  output logic       big_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      size_o <= SZ_LONG;
      big_o  <= 1'b0;
    end else if (!done_o) begin
      done_o <= 1'b1;
      size_o <= (size_e'(size_i) == SZ_RSVD) ? SZ_LONG : size_e'(size_i);
      // order is meaningless for full-width transfers
      big_o  <= big_end_i && (size_e'(size_i) == SZ_WORD || size_e'(size_i) == SZ_BYTE);
    end
  end
endmodule

// File: rtl/bm_seq.sv
module bm_seq
  import bm_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  size_e            size_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] last_idx;

  always_comb last_idx = IDX_W'(pieces(size_i, LANES) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_o <= '0;
    else if (adv_i)     idx_o <= (idx_o == last_idx) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/bm_lane_mux.sv
module bm_lane_mux
  import bm_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned IDX_W  = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  size_e             size_i,
  input  logic              big_i,
  output logic [WORD_W-1:0] piece_o
);
  logic [WORD_W-1:0] shifted [LANES];
  logic [IDX_W-1:0]  lane_sel;

  for (genvar s = 0; s < LANES; s++) begin : g_shift
    assign shifted[s] = word_i >> (s * LANE_W);
  end

  always_comb begin
    int unsigned n, lps, pos;
    n   = pieces(size_i, LANES);
    lps = lanes_per_piece(size_i, LANES);
    pos = big_i ? (n - 1 - 32'(idx_i)) : 32'(idx_i);
    lane_sel = IDX_W'(pos * lps);
  end

  assign piece_o = shifted[lane_sel];
endmodule

// File: rtl/bus_unpacker.sv
module bus_unpacker
  import bm_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               size_i,
  input  logic                     big_end_i,
  input  logic                     q_valid_i,
  input  logic [LANE_W*LANES-1:0]  q_data_i,
  output logic                     q_pop_o,
  input  logic                     rd_i,
  output logic                     rdy_o,
  output logic [LANE_W*LANES-1:0]  dout_o
);
  localparam int unsigned WORD_W = LANE_W * LANES;
  localparam int unsigned IDX_W  = $clog2(LANES);

  logic              cfg_done;
  size_e             cfg_size;
  logic              cfg_big;
  logic [IDX_W-1:0]  sub_idx;
  logic              accept, fetch;
  logic [WORD_W-1:0] hold_q, src_word, piece;

  bm_cfg_latch u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .size_i    (size_i),
    .big_end_i (big_end_i),
    .done_o    (cfg_done),
    .size_o    (cfg_size),
    .big_o     (cfg_big)
  );

  assign rdy_o    = cfg_done && (sub_idx != '0 || q_valid_i);
  assign accept   = rd_i && rdy_o;
  assign fetch    = accept && (sub_idx == '0);
  assign q_pop_o  = fetch;
  assign src_word = fetch ? q_data_i : hold_q;

  bm_seq #(.LANES(LANES)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .size_i (cfg_size),
    .idx_o  (sub_idx)
  );

  bm_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
    .word_i  (src_word),
    .idx_i   (sub_idx),
    .size_i  (cfg_size),
    .big_i   (cfg_big),
    .piece_o (piece)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dout_o <= '0;
    end else begin
      if (fetch)  hold_q <= q_data_i;
      if (accept) dout_o <= piece;
    end
  end
endmodule

// File: rtl/bus_unpacker_chk.sv
module bus_unpacker_chk #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              q_valid_i,
  input logic              q_pop_o,
  input logic              rdy_o,
  input logic [WORD_W-1:0] dout_o,
  input logic [IDX_W-1:0]  idx_i,
  input logic              cfg_done_i,
  input logic              long_i
);
  p_pop_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop_o |-> (q_valid_i && rd_i));

  p_no_pop_mid_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i != '0) |-> !q_pop_o);

  p_ready_while_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_i && idx_i != '0) |-> rdy_o);

  p_idle_before_cfg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_i |-> !rdy_o);

  p_long_no_index_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_i && long_i) |-> (idx_i == '0));

  p_hold_output_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && rdy_o) |=> $stable(dout_o));

  p_cfg_static_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_i |=> (cfg_done_i && $stable(long_i)));
endmodule

bind bus_unpacker bus_unpacker_chk #(
  .WORD_W (LANE_W * LANES),
  .IDX_W  ($clog2(LANES))
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .q_valid_i  (q_valid_i),
  .q_pop_o    (q_pop_o),
  .rdy_o      (rdy_o),
  .dout_o     (dout_o),
  .idx_i      (sub_idx),
  .cfg_done_i (cfg_done),
  .long_i     (cfg_size == bm_pkg::SZ_LONG)
);

// File: tb/bus_unpacker_test.sv
module bus_unpacker_test;
  localparam int NW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big = 1'b0;
  logic        rd = 1'b0;
  logic        q_pop, rdy;
  logic [35:0] dout;
  logic [35:0] qmem [NW];
  int          qhead;
  int          qcnt = 0;
  int          total = 0;
  int          bad = 0;
  logic        q_valid;
  logic [35:0] q_data;

  always #2 clk = ~clk;

  assign q_valid = qhead < qcnt;
  assign q_data  = (qhead < NW) ? qmem[qhead] : 36'h0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) qhead <= 0;
    else if (q_pop) qhead <= qhead + 1;

  bus_unpacker uut (
    .clk_i(clk), .rst_ni(rst_n), .size_i(size_sel), .big_end_i(big),
    .q_valid_i(q_valid), .q_data_i(q_data), .q_pop_o(q_pop),
    .rd_i(rd), .rdy_o(rdy), .dout_o(dout)
  );

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [35:0] mk_word(int k);
    logic [35:0] w;
    for (int j = 0; j < 4; j++) w[9*j +: 9] = 9'((k << 5) + j * 37 + 5);
    return w;
  endfunction

  function automatic int n_of(logic [1:0] s);
    return (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] exp_piece(logic [35:0] w, logic [1:0] s, logic b, int i);
    int n, wd, p;
    logic [63:0] m;
    n  = n_of(s);
    wd = 36 / n;
    p  = (n > 1 && b) ? n - 1 - i : i;
    m  = (64'h1 << wd) - 1;
    return 36'((64'(w) >> (wd * p)) & m);
  endfunction

  task automatic run_mode(logic [1:0] s, logic b);
    int n, wd;
    string tag;
    logic [35:0] m, last;
    n  = n_of(s);
    wd = 36 / n;
    m  = 36'(((64'h1 << wd) - 1));
    tag = (n == 1) ? (b ? "R7" : "R3") : (b ? "R6" : ((n == 2) ? "R4" : "R5"));
    @(negedge clk);
    rst_n = 1'b0; size_sel = s; big = b; rd = 1'b0;
    for (int k = 0; k < NW; k++) qmem[k] = mk_word(k + 4 * int'(s) + (b ? 2 : 0));
    qcnt = NW;
    @(negedge clk);
    // R1 reset state
    chk("R1", {dout, rdy, q_pop}, 38'h0);
    rst_n = 1'b1;
    #0.5 chk("R1", {35'h0, rdy}, 36'h0);
    @(negedge clk);
    // R2: flip config after capture
    size_sel = ~s; big = ~b;
    for (int k = 0; k < NW; k++) begin
      for (int i = 0; i < n; i++) begin
        rd = 1'b1;
        #0.5 chk("R10", {35'h0, q_pop}, {35'h0, (i == 0)});
        @(negedge clk);
        chk(tag, dout & m, exp_piece(qmem[k], s, b, i));
        if (k == 0 && i == 0) chk("R2", dout & m, exp_piece(qmem[k], s, b, i));
        if (k == NW - 1 && i == 0 && n > 1)
          chk("R8", {34'h0, q_valid, rdy}, 36'h1);
        if (k == 1 && i == 0) begin
          rd = 1'b0;
          last = dout;
          @(negedge clk);
          @(negedge clk);
          chk("R9", dout, last);
        end
      end
    end
    // drained: read refused
    last = dout;
    rd = 1'b1;
    #0.5 chk("R8", {34'h0, rdy, q_pop}, 36'h0);
    @(negedge clk);
    chk("R8", dout, last);
    rd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++)
        run_mode(2'(s), 1'(b));
    finish_run();
  end
endmodule